// File: doc/BRIEF.md
# Trigger-Latency Pipeline Cell Manager

This block does the address bookkeeping for a circular analogue sample pipeline in a multi-channel front-end readout chip. On each beam-crossing strobe the write pointer moves to the next cell that is not held, and that cell becomes the newest sample. Sampling never pauses. Every crossing gets a cell, even while triggered cells wait for conversion or are being converted.

When a first-level trigger accept arrives, the block finds the cell that was written a programmed number of crossings earlier. It locks that cell against overwrite and puts it in a small queue. A history of crossing-to-cell assignments is kept, so the lookup stays correct after the pointer has skipped over held cells. The queue hands cell addresses to a digitiser one at a time, oldest first. The digitiser answers each address with a done pulse, and the cell then returns to the free pool. The analogue storage, the converter and the channel data are not part of the block; only addresses, lock state and queue control are modelled.

Top module: `pcm_cell_mgr`

## Requirements
- R1: After reset the write cell is 0 and no cell is busy. The queue is empty, dig_valid_o is low, and ovf_o and lat_err_o are low. The history then reads as if crossing k before the newest had used cell (46 - k) mod 46.
- R2: Each cycle with xing_i high moves wr_cell_o to the next cell in ascending order, modulo 46, that is not blocked. Sampling continues whatever the queue holds. Without xing_i, wr_cell_o holds its value.
- R3: The write pointer never lands on a busy cell. This includes a cell locked by an accept in the same cycle.
- R4: An accept with latency L (0 to 42) locks the cell that was newest L crossings before the current newest cell; L = 0 means wr_cell_o itself. When the accept and a strobe come in the same cycle, the lookup uses the history from before that strobe. The lock shows in cell_busy_o (bit n is cell n) in the next cycle.
- R5: Queued cells are offered oldest first. dig_valid_o is high whenever the queue is not empty, and dig_cell_o then carries the oldest cell.
- R6: done_i while dig_valid_o is high removes the oldest entry. Its busy bit clears in the next cycle.
- R7: At most 4 cells are queued. An accept that would add a fifth cell is dropped, leaves the queue and the busy cells unchanged, and sets ovf_o. ovf_o then stays high until reset.
- R8: An accept whose target cell is already busy adds no entry and does not set ovf_o.
- R9: A latency above 42 sets lat_err_o in the next cycle. An accept given with such a latency is ignored.
- R10: q_level_o equals the number of queued cells, and it equals the number of busy cells.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| xing_i | input | 1 | Beam-crossing strobe |
| l1a_i | input | 1 | First-level trigger accept |
| lat_cfg_i | input | 6 | Programmed trigger latency in crossings |
| done_i | input | 1 | Digitiser finished the offered cell |
| wr_cell_o | output | 6 | Cell holding the newest sample |
| cell_busy_o | output | 46 | Lock state, one bit per cell |
| dig_valid_o | output | 1 | A cell address is offered for conversion |
| dig_cell_o | output | 6 | Oldest queued cell |
| q_level_o | output | 3 | Number of queued cells |
| ovf_o | output | 1 | Sticky trigger overflow |
| lat_err_o | output | 1 | Programmed latency out of range |

## Verification
Some properties are checked every cycle. The write pointer never lands on a busy cell and holds without a strobe. The busy count always matches the queue level, and the level never goes above four. An offered cell is always busy, and a done frees that cell by the next cycle. The overflow flag stays high once set, and a bad latency raises the error flag and adds nothing to the queue. The bench scenarios are needed for the rest. Only they can show that the right cell is picked for a given latency after the pointer has skipped held cells, that an accept and a strobe in the same cycle use the history from before the strobe, that conversion runs in trigger order, and that merged and dropped accepts behave as required.

// File: rtl/pcm_pkg.sv
package pcm_pkg;
  localparam int unsigned DEF_NCELLS = 46;
  localparam int unsigned DEF_QDEPTH = 4;

  typedef enum logic [2:0] {
    ACC_IDLE,
    ACC_TAKE,
    ACC_MERGE,
    ACC_DROP,
    ACC_BADLAT
  } acc_e;
endpackage

// File: rtl/pcm_next_free.sv
module pcm_next_free #(
  parameter int unsigned NCELLS = 46,
  parameter int unsigned CW     = 6
) (
  input  logic [CW-1:0]     cur_i,
  input  logic [NCELLS-1:0] blocked_i,
  output logic [CW-1:0]     nxt_o
);
  always_comb begin
    logic found;
    int   idx;
    found = 1'b0;
    nxt_o = cur_i;
    for (int i = 1; i <= int'(NCELLS); i++) begin
      idx = int'(cur_i) + i;
      if (idx >= int'(NCELLS)) idx = idx - int'(NCELLS);
      if (!found && !blocked_i[idx]) begin
        found = 1'b1;
        nxt_o = CW'(idx);
      end
    end
  end
endmodule

// File: rtl/pcm_hist.sv
module pcm_hist #(
  parameter int unsigned NCELLS = 46,
  parameter int unsigned CW     = 6,
  parameter int unsigned HDEPTH = 43,
  parameter int unsigned LW     = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          shift_en_i,
  input  logic [CW-1:0] new_cell_i,
  input  logic [LW-1:0] lat_sel_i,
  output logic [CW-1:0] newest_o,
  output logic [CW-1:0] tap_o
);
  logic [CW-1:0] hist_q [HDEPTH];
  logic [CW-1:0] hist_d [HDEPTH];

  always_comb begin
    for (int k = 0; k < int'(HDEPTH); k++) hist_d[k] = hist_q[k];
    if (shift_en_i) begin
      hist_d[0] = new_cell_i;
      for (int k = 1; k < int'(HDEPTH); k++) hist_d[k] = hist_q[k-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < int'(HDEPTH); k++)
        hist_q[k] <= CW'((int'(NCELLS) - k) % int'(NCELLS));
    end else begin
      for (int k = 0; k < int'(HDEPTH); k++) hist_q[k] <= hist_d[k];
    end
  end

  always_comb begin
    tap_o = '0;
    if (int'(lat_sel_i) < int'(HDEPTH)) tap_o = hist_q[int'(lat_sel_i)];
  end

  assign newest_o = hist_q[0];
endmodule

// File: rtl/pcm_lockq.sv
module pcm_lockq #(
  parameter int unsigned NCELLS = 46,
  parameter int unsigned QDEPTH = 4,
  parameter int unsigned CW     = 6,
  parameter int unsigned QW     = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_i,
  input  logic [CW-1:0]     push_cell_i,
  input  logic              pop_i,
  output logic [NCELLS-1:0] busy_o,
  output logic [CW-1:0]     head_o,
  output logic [QW-1:0]     level_o,
  output logic              full_o
);
  localparam int unsigned PW = (QDEPTH > 1) ? $clog2(QDEPTH) : 1;
  localparam logic [PW-1:0] PLAST = PW'(QDEPTH - 1);

  logic [CW-1:0]     mem_q [QDEPTH];
  logic [CW-1:0]     mem_d [QDEPTH];
  logic [PW-1:0]     rd_q, rd_d, wr_q, wr_d;
  logic [QW-1:0]     cnt_q, cnt_d;
  logic [NCELLS-1:0] busy_q, busy_d;
  logic              do_pop, do_push;

  assign do_pop  = pop_i && (cnt_q != '0);
  assign do_push = push_i && (cnt_q != QW'(QDEPTH));

  always_comb begin
    for (int k = 0; k < int'(QDEPTH); k++) mem_d[k] = mem_q[k];
    rd_d   = rd_q;
    wr_d   = wr_q;
    cnt_d  = cnt_q;
    busy_d = busy_q;
    if (do_pop) begin
      busy_d[mem_q[rd_q]] = 1'b0;
      rd_d  = (rd_q == PLAST) ? '0 : rd_q + 1'b1;
    end
    if (do_push) begin
      mem_d[wr_q]         = push_cell_i;
      busy_d[push_cell_i] = 1'b1;
      wr_d  = (wr_q == PLAST) ? '0 : wr_q + 1'b1;
    end
    case ({do_push, do_pop})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < int'(QDEPTH); k++) mem_q[k] <= '0;
      rd_q   <= '0;
      wr_q   <= '0;
      cnt_q  <= '0;
      busy_q <= '0;
    end else begin
      for (int k = 0; k < int'(QDEPTH); k++) mem_q[k] <= mem_d[k];
      rd_q   <= rd_d;
      wr_q   <= wr_d;
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
    end
  end

  assign busy_o  = busy_q;
  assign head_o  = mem_q[rd_q];
  assign level_o = cnt_q;
  assign full_o  = (cnt_q == QW'(QDEPTH));
endmodule

// File: rtl/pcm_cell_mgr.sv
module pcm_cell_mgr #(
  parameter int unsigned NCELLS = pcm_pkg::DEF_NCELLS,
  parameter int unsigned QDEPTH = pcm_pkg::DEF_QDEPTH,
  parameter int unsigned CW     = $clog2(NCELLS),
  parameter int unsigned LW     = $clog2(NCELLS - QDEPTH + 1),
  parameter int unsigned QW     = $clog2(QDEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xing_i,
  input  logic              l1a_i,
  input  logic [LW-1:0]     lat_cfg_i,
  input  logic              done_i,
  output logic [CW-1:0]     wr_cell_o,
  output logic [NCELLS-1:0] cell_busy_o,
  output logic              dig_valid_o,
  output logic [CW-1:0]     dig_cell_o,
  output logic [QW-1:0]     q_level_o,
  output logic              ovf_o,
  output logic              lat_err_o
);
  import pcm_pkg::*;

  localparam int unsigned MAX_LAT = NCELLS - QDEPTH;
  localparam int unsigned HDEPTH  = MAX_LAT + 1;

  logic [CW-1:0]     newest, tap, nxt;
  logic [NCELLS-1:0] busy, blocked;
  logic [QW-1:0]     level;
  logic              full, lat_ok;
  acc_e              acc;
  logic              ovf_q, ovf_d, err_q, err_d;

  assign lat_ok = (int'(lat_cfg_i) <= int'(MAX_LAT));

  always_comb begin
    if (!l1a_i)         acc = ACC_IDLE;
    else if (!lat_ok)   acc = ACC_BADLAT;
    else if (busy[tap]) acc = ACC_MERGE;
    else if (full)      acc = ACC_DROP;
    else                acc = ACC_TAKE;
  end

  always_comb begin
    blocked = busy;
    if (acc == ACC_TAKE) blocked[tap] = 1'b1;
  end

  pcm_next_free #(.NCELLS(NCELLS), .CW(CW)) u_next (
    .cur_i     (newest),
    .blocked_i (blocked),
    .nxt_o     (nxt)
  );

  pcm_hist #(.NCELLS(NCELLS), .CW(CW), .HDEPTH(HDEPTH), .LW(LW)) u_hist (
    .clk        (clk),
    .rst_n      (rst_n),
    .shift_en_i (xing_i),
    .new_cell_i (nxt),
    .lat_sel_i  (lat_cfg_i),
    .newest_o   (newest),
    .tap_o      (tap)
  );

  pcm_lockq #(.NCELLS(NCELLS), .QDEPTH(QDEPTH), .CW(CW), .QW(QW)) u_lockq (
    .clk         (clk),
    .rst_n       (rst_n),
    .push_i      (acc == ACC_TAKE),
    .push_cell_i (tap),
    .pop_i       (done_i),
    .busy_o      (busy),
    .head_o      (dig_cell_o),
    .level_o     (level),
    .full_o      (full)
  );

  always_comb begin
    ovf_d = ovf_q || (acc == ACC_DROP);
    err_d = !lat_ok;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      ovf_q <= ovf_d;
      err_q <= err_d;
    end
  end

  assign wr_cell_o   = newest;
  assign cell_busy_o = busy;
  assign q_level_o   = level;
  assign dig_valid_o = (level != '0);
  assign ovf_o       = ovf_q;
  assign lat_err_o   = err_q;
endmodule

// File: rtl/pcm_cell_mgr_chk.sv
module pcm_cell_mgr_chk #(
  parameter int unsigned NCELLS = 46,
  parameter int unsigned QDEPTH = 4,
  parameter int unsigned CW     = 6,
  parameter int unsigned LW     = 6,
  parameter int unsigned QW     = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              xing_i,
  input logic              l1a_i,
  input logic [LW-1:0]     lat_cfg_i,
  input logic              done_i,
  input logic [CW-1:0]     wr_cell_o,
  input logic [NCELLS-1:0] cell_busy_o,
  input logic              dig_valid_o,
  input logic [CW-1:0]     dig_cell_o,
  input logic [QW-1:0]     q_level_o,
  input logic              ovf_o,
  input logic              lat_err_o
);
  localparam int unsigned MAX_LAT = NCELLS - QDEPTH;

  logic [CW-1:0] served_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) served_q <= '0;
    else        served_q <= dig_cell_o;
  end

  // R3
  a_r3_no_write_locked: assert property (@(posedge clk) disable iff (!rst_n)
    xing_i |=> !cell_busy_o[wr_cell_o]) else $error("R3 write on busy cell");
  // R2
  a_r2_hold_no_xing: assert property (@(posedge clk) disable iff (!rst_n)
    !xing_i |=> $stable(wr_cell_o)) else $error("R2 pointer moved");
  // R2
  a_r2_moves_on_xing: assert property (@(posedge clk) disable iff (!rst_n)
    xing_i |=> wr_cell_o != $past(wr_cell_o)) else $error("R2 pointer stuck");
  // R10
  a_r10_level_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(cell_busy_o) == int'(q_level_o)) else $error("R10 level mismatch");
  // R7
  a_r7_max_level: assert property (@(posedge clk) disable iff (!rst_n)
    int'(q_level_o) <= int'(QDEPTH)) else $error("R7 level too high");
  // R7
  a_r7_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_o |=> ovf_o) else $error("R7 overflow cleared");
  // R5
  a_r5_offered_busy: assert property (@(posedge clk) disable iff (!rst_n)
    dig_valid_o |-> cell_busy_o[dig_cell_o]) else $error("R5 offered cell not busy");
  // R6
  a_r6_release: assert property (@(posedge clk) disable iff (!rst_n)
    (dig_valid_o && done_i) |=> !cell_busy_o[served_q]) else $error("R6 not released");
  // R9
  a_r9_err_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(lat_cfg_i) > int'(MAX_LAT)) |=> lat_err_o) else $error("R9 no error flag");
  // R9
  a_r9_ignore: assert property (@(posedge clk) disable iff (!rst_n)
    (l1a_i && int'(lat_cfg_i) > int'(MAX_LAT)) |=> q_level_o <= $past(q_level_o))
    else $error("R9 bad accept queued");
endmodule

bind pcm_cell_mgr pcm_cell_mgr_chk #(
  .NCELLS(NCELLS), .QDEPTH(QDEPTH), .CW(CW), .LW(LW), .QW(QW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .xing_i(xing_i), .l1a_i(l1a_i),
  .lat_cfg_i(lat_cfg_i), .done_i(done_i), .wr_cell_o(wr_cell_o),
  .cell_busy_o(cell_busy_o), .dig_valid_o(dig_valid_o),
  .dig_cell_o(dig_cell_o), .q_level_o(q_level_o), .ovf_o(ovf_o),
  .lat_err_o(lat_err_o)
);

// File: tb/pcm_cell_mgr_bench.sv
module pcm_cell_mgr_bench;
  localparam int NC = 46;
  localparam int QD = 4;
  localparam int ML = NC - QD;

  logic          clk, rst_n, xing, l1a, done;
  logic [5:0]    lat;
  logic [5:0]    wr_cell, dig_cell;
  logic [NC-1:0] busy;
  logic          dig_valid, ovf, lat_err;
  logic [2:0]    level;

  pcm_cell_mgr u_pcm_cell_mgr (
    .clk(clk), .rst_n(rst_n), .xing_i(xing), .l1a_i(l1a), .lat_cfg_i(lat),
    .done_i(done), .wr_cell_o(wr_cell), .cell_busy_o(busy),
    .dig_valid_o(dig_valid), .dig_cell_o(dig_cell), .q_level_o(level),
    .ovf_o(ovf), .lat_err_o(lat_err)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int n_chk, n_bad;
  bit finished;

  int          m_wr, m_cnt;
  int          m_hist [ML+1];
  int          m_q [QD];
  bit [NC-1:0] m_lock;
  bit          m_ovf, m_err;

  task automatic chk(string req, string what, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int next_free(int cur, bit [NC-1:0] blk);
    for (int i = 1; i <= NC; i++) begin
      int c;
      c = (cur + i) % NC;
      if (!blk[c]) return c;
    end
    return cur;
  endfunction

  task automatic model_reset();
    m_wr = 0; m_cnt = 0; m_lock = '0; m_ovf = 0; m_err = 0;
    for (int k = 0; k <= ML; k++) m_hist[k] = (NC - k) % NC;
  endtask

  task automatic model_step(bit x, bit a, int l, bit d);
    bit          ok, take;
    int          tgt;
    bit [NC-1:0] blk;
    ok   = (l <= ML);
    tgt  = ok ? m_hist[l] : 0;
    take = 0;
    if (a && ok && !m_lock[tgt]) begin
      if (m_cnt < QD) take = 1;
      else            m_ovf = 1;
    end
    blk = m_lock;
    if (take) blk[tgt] = 1'b1;
    if (x) begin
      int nx;
      nx = next_free(m_wr, blk);
      for (int k = ML; k > 0; k--) m_hist[k] = m_hist[k-1];
      m_hist[0] = nx;
      m_wr = nx;
    end
    if (d && m_cnt > 0) begin
      m_lock[m_q[0]] = 1'b0;
      for (int k = 0; k < QD - 1; k++) m_q[k] = m_q[k+1];
      m_cnt--;
    end
    if (take) begin
      m_q[m_cnt] = tgt;
      m_cnt++;
      m_lock[tgt] = 1'b1;
    end
    m_err = !ok;
  endtask

  task automatic compare_all();
    chk("R2", "wr_cell", wr_cell, m_wr);
    chk("R4", "busy", busy, m_lock);
    chk("R5", "dig_valid", dig_valid, m_cnt != 0);
    if (m_cnt != 0) chk("R5", "dig_cell", dig_cell, m_q[0]);
    chk("R10", "level", level, m_cnt);
    chk("R7", "ovf", ovf, m_ovf);
    chk("R9", "lat_err", lat_err, m_err);
  endtask

  task automatic cyc(bit x, bit a, int l, bit d);
    xing = x; l1a = a; lat = 6'(l); done = d;
    @(posedge clk);
    model_step(x, a, l, d);
    @(negedge clk);
    compare_all();
  endtask

  task automatic do_reset();
    rst_n = 1'b0; xing = 0; l1a = 0; done = 0; lat = '0;
    repeat (3) @(negedge clk);
    model_reset();
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(4 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    int seed;
    n_chk = 0; n_bad = 0; finished = 0;
    seed = 1234;
    void'($urandom(seed));
    do_reset();
    // R1 reset state
    chk("R1", "wr_cell", wr_cell, 0);
    chk("R1", "busy", busy, 0);
    chk("R1", "level", level, 0);
    chk("R1", "dig_valid", dig_valid, 0);
    chk("R1", "ovf", ovf, 0);
    chk("R1", "lat_err", lat_err, 0);
    // R2 plain advance
    repeat (3) cyc(1, 0, 0, 0);
    chk("R2", "wr after 3", wr_cell, 3);
    // R4 latency 2 from newest 3 -> cell 1
    cyc(0, 1, 2, 0);
    chk("R4", "locked cell", dig_cell, 1);
    chk("R4", "level", level, 1);
    // R8 same target again merges
    cyc(0, 1, 2, 0);
    chk("R8", "merged level", level, 1);
    chk("R8", "ovf", ovf, 0);
    // R4/R3 accept with strobe, latency 0 -> cell 3, pointer goes to 4
    cyc(1, 1, 0, 0);
    chk("R3", "wr skips new lock", wr_cell, 4);
    chk("R4", "cell 3 busy", busy[3], 1);
    cyc(1, 1, 4, 0);   // locks cell 0
    cyc(1, 1, 3, 0);   // locks cell 2
    chk("R7", "full level", level, 4);
    // R7 fifth distinct accept dropped
    cyc(1, 1, 1, 0);
    chk("R7", "ovf set", ovf, 1);
    chk("R7", "level kept", level, 4);
    chk("R7", "busy kept", busy, 46'hF);
    // R3 wrap skips locked cells 0..3
    repeat (39) cyc(1, 0, 0, 0);
    chk("R3", "wrap skip", wr_cell, 4);
    // R5/R6 oldest first: 1,3,0,2
    chk("R5", "head", dig_cell, 1);
    cyc(0, 0, 0, 1);
    chk("R6", "cell1 freed", busy[1], 0);
    chk("R5", "second", dig_cell, 3);
    cyc(0, 0, 0, 1);
    chk("R5", "third", dig_cell, 0);
    cyc(0, 0, 0, 1);
    chk("R5", "fourth", dig_cell, 2);
    cyc(0, 0, 0, 1);
    chk("R5", "empty", dig_valid, 0);
    chk("R7", "ovf sticky", ovf, 1);
    // R9 bad latency
    cyc(0, 1, 50, 0);
    chk("R9", "lat_err", lat_err, 1);
    chk("R9", "ignored", level, 0);
    cyc(0, 0, ML, 0);
    chk("R9", "max latency ok", lat_err, 0);
    // R1 reset clears overflow
    do_reset();
    chk("R1", "ovf after reset", ovf, 0);
    // random traffic
    for (int i = 0; i < 4000; i++) begin
      bit x, a, d;
      int l;
      x = ($urandom % 10) < 8;
      a = ($urandom % 10) < 2;
      d = ($urandom % 10) < 3;
      l = (($urandom % 16) == 0) ? 43 + int'($urandom % 21) : int'($urandom % (ML + 1));
      cyc(x, a, l, d);
    end
    summary();
  end
endmodule